// File: doc/BRIEF.md
# Root Port Connect Status Tracker

This block holds the connection state of one downstream root port of a host controller. It watches a sampled device-present line and a sampled low-speed line, and filters the presence input against a bit-time tick. From these it keeps a connect status, a low-speed flag and a port-enable bit, along with two sticky change flags that software clears by writing ones.

A controller reset makes the port look disconnected even when a device is attached. The port drops out of the enabled state and both change flags are raised. After the reset input falls, the block waits a fixed number of bit times before it samples presence and speed again. Changes in presence are only accepted after the new level has held for a few bit times.

Software reads the packed status word and writes the same layout. In a write, bit 2 requests enable, and bits 1 and 3 are write-one-to-clear.

Top module: `port_conn_tracker`

## Requirements
- R1: `status_o` packs connect status at bit 0, connect-change at bit 1, enable at bit 2, enable-change at bit 3 and low-speed at bit 8. All other bits read 0, and the separate outputs mirror those bits.
- R2: While `hc_reset_i` is high, connect, enable and low-speed are forced to 0 from the next clock edge on, whatever `dev_present_i` shows.
- R3: While `hc_reset_i` is high, both change flags are set from the next clock edge on. A write-one-to-clear in those cycles has no effect.
- R4: After reset (chip or controller) is released, connect stays 0 for SETTLE_TICKS-1 ticks. On the edge that samples the SETTLE_TICKS-th tick, connect takes `dev_present_i`, low-speed takes `dev_present_i & dev_low_speed_i`, and connect-change is set if a device is present.
- R5: Once running, a `dev_present_i` level that differs from connect on STABLE_TICKS consecutive ticks is committed on the last of those ticks. Committing updates connect and low-speed and sets connect-change. A return to the connected level before that restarts the count.
- R6: A committed disconnect clears enable in the same edge and sets enable-change if enable was 1.
- R7: A write loads enable with `wr_data_i[2]` and `connect`, so writing 1 while disconnected leaves enable at 0. Enable is never 1 while connect is 0.
- R8: Writing 1 to bit 1 or bit 3 clears that change flag, and writing 0 leaves it. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| dev_present_i | input | 1 | Sampled device-present level |
| dev_low_speed_i | input | 1 | Sampled low-speed indication |
| hc_reset_i | input | 1 | Controller reset, active high, level |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Write data in status layout |
| status_o | output | 16 | Packed port status word |
| conn_o | output | 1 | Connect status |
| conn_chg_o | output | 1 | Connect-change flag |
| en_o | output | 1 | Port enable |
| en_chg_o | output | 1 | Enable-change flag |
| low_speed_o | output | 1 | Low-speed device attached |

## Verification
Every result of this block comes from a single register stage. Writes, reset effects and tick-driven commits therefore show on the outputs at the edge that samples the stimulus. The bench drives every stimulus for exactly one cycle from a falling edge and reads the outputs at the next falling edge. This is half a cycle after the edge that is due to change them. Window boundaries are checked one tick short of the limit and again at the limit. This covers both the settle count after reset and the presence filter. Each such check lands in the cycle straight after the deciding tick.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
  localparam int unsigned STAT_W       = 16;
  localparam int unsigned CONN_BIT     = 0;
  localparam int unsigned CONN_CHG_BIT = 1;
  localparam int unsigned EN_BIT       = 2;
  localparam int unsigned EN_CHG_BIT   = 3;
  localparam int unsigned LS_BIT       = 8;
  localparam int unsigned N_CHG        = 2;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_RUN    = 1'b1
  } phase_e;
endpackage

// File: rtl/pct_settle.sv
`timescale 1ns/1ps
module pct_settle import pct_pkg::*; #(
  parameter int unsigned SETTLE_TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hc_reset_i,
  input  logic tick_i,
  output logic run_o,
  output logic detect_o
);
  localparam int unsigned CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else if (hc_reset_i) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_SETTLE && tick_i) begin
      if (cnt_q == LAST) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o    = (phase_q == PH_RUN) && !hc_reset_i;
  assign detect_o = (phase_q == PH_SETTLE) && !hc_reset_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/pct_debounce.sv
`timescale 1ns/1ps
module pct_debounce #(
  parameter int unsigned STABLE_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic present_i,
  input  logic conn_i,
  output logic commit_o
);
  localparam int unsigned CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = present_i ^ conn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || !differ) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign commit_o = run_i && differ && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/pct_chg_bit.sv
`timescale 1ns/1ps
module pct_chg_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // hardware set wins
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/port_conn_tracker.sv
`timescale 1ns/1ps
module port_conn_tracker import pct_pkg::*; #(
  parameter int unsigned SETTLE_TICKS = 64,
  parameter int unsigned STABLE_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              dev_present_i,
  input  logic              dev_low_speed_i,
  input  logic              hc_reset_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              conn_o,
  output logic              conn_chg_o,
  output logic              en_o,
  output logic              en_chg_o,
  output logic              low_speed_o
);
  localparam logic [STAT_W-1:0] WR_USED =
    STAT_W'((1 << EN_BIT) | (1 << CONN_CHG_BIT) | (1 << EN_CHG_BIT));

  logic conn_q, en_q, ls_q;
  logic run, detect, commit;
  logic [N_CHG-1:0] chg_set, chg_clr, chg_q;
  logic unused_wr;

  assign unused_wr = ^(wr_data_i & ~WR_USED);

  pct_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .hc_reset_i(hc_reset_i),
    .tick_i(bit_tick_i), .run_o(run), .detect_o(detect)
  );

  pct_debounce #(.STABLE_TICKS(STABLE_TICKS)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(bit_tick_i),
    .present_i(dev_present_i), .conn_i(conn_q), .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      en_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else if (hc_reset_i) begin
      conn_q <= 1'b0;
      en_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else if (detect || commit) begin
      conn_q <= dev_present_i;
      ls_q   <= dev_present_i & dev_low_speed_i;
      if (!dev_present_i) en_q <= 1'b0;
    end else if (wr_en_i) begin
      en_q <= wr_data_i[EN_BIT] & conn_q;
    end
  end

  // index 0: connect-change, index 1: enable-change
  assign chg_set[0] = hc_reset_i || (detect && dev_present_i) || commit;
  assign chg_set[1] = hc_reset_i || (commit && !dev_present_i && en_q);
  assign chg_clr[0] = wr_en_i && wr_data_i[CONN_CHG_BIT];
  assign chg_clr[1] = wr_en_i && wr_data_i[EN_CHG_BIT];

  for (genvar g = 0; g < N_CHG; g++) begin : g_chg
    pct_chg_bit u_bit (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(chg_set[g]), .clr_i(chg_clr[g]), .q_o(chg_q[g])
    );
  end

  always_comb begin
    status_o               = '0;
    status_o[CONN_BIT]     = conn_q;
    status_o[CONN_CHG_BIT] = chg_q[0];
    status_o[EN_BIT]       = en_q;
    status_o[EN_CHG_BIT]   = chg_q[1];
    status_o[LS_BIT]       = ls_q;
  end

  assign conn_o      = conn_q;
  assign conn_chg_o  = chg_q[0];
  assign en_o        = en_q;
  assign en_chg_o    = chg_q[1];
  assign low_speed_o = ls_q;
endmodule

// File: rtl/pct_checker.sv
`timescale 1ns/1ps
module pct_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic hc_reset_i,
  input logic conn_o,
  input logic conn_chg_o,
  input logic en_o,
  input logic en_chg_o,
  input logic low_speed_o
);
  a_r2_reset_disconnects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_reset_i |=> (!conn_o && !en_o && !low_speed_o));

  a_r3_reset_flags_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_reset_i |=> (conn_chg_o && en_chg_o));

  a_r7_enable_needs_conn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> conn_o);

  a_r4_ls_needs_conn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_speed_o |-> conn_o);

  a_r5_conn_edge_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(conn_o) |-> conn_chg_o);

  a_r6_disable_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_o) && $fell(conn_o)) |-> en_chg_o);
endmodule

bind port_conn_tracker pct_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hc_reset_i(hc_reset_i),
  .conn_o(conn_o), .conn_chg_o(conn_chg_o), .en_o(en_o),
  .en_chg_o(en_chg_o), .low_speed_o(low_speed_o)
);

// File: tb/port_conn_tracker_tb.sv
`timescale 1ns/1ps
module port_conn_tracker_tb;
  localparam int SETTLE = 64;
  localparam int STABLE = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0, present = 1'b0, ls = 1'b0, hc_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic conn, conn_chg, en, en_chg, low_speed;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  port_conn_tracker #(.SETTLE_TICKS(SETTLE), .STABLE_TICKS(STABLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(tick), .dev_present_i(present),
    .dev_low_speed_i(ls), .hc_reset_i(hc_rst), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .status_o(status), .conn_o(conn),
    .conn_chg_o(conn_chg), .en_o(en), .en_chg_o(en_chg), .low_speed_o(low_speed)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: status actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus driven from a falling edge; returns at next falling edge
  task automatic cyc(input logic t, input logic w, input logic [15:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0);
  endtask

  task automatic wr(input logic [15:0] d);
    cyc(1'b0, 1'b1, d);
  endtask

  task automatic t_power_up();
    chk("R1 reset state", status, 16'h0000);
    present = 1'b1; ls = 1'b0;
    ticks(SETTLE - 1);
    chk("R4 before settle end", status, 16'h0000);
    ticks(1);
    chk("R4 detect at settle end", status, 16'h0003);
    chk("R1 mirrors", {11'b0, low_speed, en_chg, en, conn_chg, conn}, 16'h0003);
  endtask

  task automatic t_enable_and_clear();
    wr(16'h0004);
    chk("R7 enable while connected", status, 16'h0007);
    wr(16'h0006);
    chk("R8 clear connect-change", status, 16'h0005);
    wr(16'h0000);
    chk("R7 write 0 disables, R8 zero leaves flags", status, 16'h0001);
    wr(16'h0004);
    chk("R7 re-enable", status, 16'h0005);
  endtask

  task automatic t_disconnect();
    present = 1'b0;
    ticks(STABLE - 1);
    present = 1'b1;
    ticks(1);
    chk("R5 glitch ignored", status, 16'h0005);
    present = 1'b0;
    ticks(STABLE - 1);
    chk("R5 not yet stable", status, 16'h0005);
    ticks(1);
    chk("R5 R6 disconnect commit", status, 16'h000A);
    wr(16'h000A);
    chk("R8 clear both flags", status, 16'h0000);
    wr(16'h0004);
    chk("R7 enable ignored while disconnected", status, 16'h0000);
  endtask

  task automatic t_low_speed_connect();
    present = 1'b1; ls = 1'b1;
    ticks(STABLE);
    chk("R5 low-speed connect", status, 16'h0103);
    wr(16'h0002);
    chk("R8 clear connect-change", status, 16'h0101);
    wr(16'h0004);
    chk("R7 enable low-speed port", status, 16'h0105);
  endtask

  task automatic t_hc_reset();
    @(negedge clk);
    hc_rst = 1'b1; wr_en = 1'b1; wr_data = 16'h000A;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R2 R3 R8 reset beats clear", status, 16'h000A);
    wr(16'h000A);
    chk("R3 clear ignored during reset", status, 16'h000A);
    @(negedge clk);
    hc_rst = 1'b0;
    ticks(SETTLE - 1);
    chk("R4 still disconnected in settle", status, 16'h000A);
    ticks(1);
    chk("R4 redetect low-speed", status, 16'h010B);
  endtask

  task automatic t_set_beats_clear();
    wr(16'h000A);
    chk("R8 clear after reset", status, 16'h0101);
    present = 1'b0; ls = 1'b0;
    ticks(STABLE - 1);
    cyc(1'b1, 1'b1, 16'h0002);
    chk("R8 hardware set wins", status, 16'h0002);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_power_up();
    t_enable_and_clear();
    t_disconnect();
    t_low_speed_connect();
    t_hc_reset();
    t_set_beats_clear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule